// File: doc/BRIEF.md
# Load-Use Stall and Taken-Branch Squash Controller

This block is the hazard control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose branches are decided in the decode stage. It looks at the instruction now in execute and the instruction now in decode. It then tells the fetch stage, the fetch/decode register and the decode/execute register what to do on the next clock edge.

A load in execute produces its value only at the end of the memory stage. If the very next instruction reads the load's destination register, forwarding cannot deliver the value in time. The controller therefore holds the program counter and the fetch/decode register for one cycle, and asks the decode/execute register to capture all-zero control fields. This puts a bubble behind the load. Once the load has moved on and the bubble sits in execute, the condition clears and the held instruction proceeds.

Branches are predicted not taken. When decode reports a taken branch, the instruction fetched behind it is wrong. The controller asks the fetch/decode register to turn that instruction into an all-zero no-op on the next edge, so a taken branch costs exactly one slot. A stall outranks a taken branch: while decode is held, no flush is issued, and the branch is honoured only once it leaves the held slot. The block is purely combinational and has no stream interfaces. All pins are plain control levels that take effect at the pipeline's next clock edge.

Top module: `hzd_ctrl`

## Requirements
- R1: When `ex_mem_rd` is 1, `ex_rt` is nonzero and `ex_rt` equals `id_rs`, the block stalls: `idex_zero_ctl` is 1.
- R2: When `ex_mem_rd` is 1, `ex_rt` is nonzero and `ex_rt` equals `id_rt`, the block stalls, including when only `id_rt` matches.
- R3: When `ex_mem_rd` is 0, no stall is requested, whatever the register numbers are.
- R4: A load whose `ex_rt` is register 0 never causes a stall.
- R5: During a stall `pc_en` and `ifid_en` are both 0. Otherwise both are 1.
- R6: `idex_zero_ctl` is 1 exactly in stall cycles and 0 in all others.
- R7: When `id_br_taken` is 1 and there is no stall, `ifid_flush` is 1 while `pc_en` and `ifid_en` stay 1.
- R8: When a stall and `id_br_taken` coincide, `ifid_flush` is 0 and the stall outputs of R5 and R6 apply.
- R9: With no load-use match and no taken branch (and during bench reset with all inputs 0), the outputs are `pc_en`=1, `ifid_en`=1, `idex_zero_ctl`=0 and `ifid_flush`=0.
- R10: The stall lasts only while its condition holds. In the cycle after a stall, the bubble in execute (`ex_mem_rd`=0) releases it, and a branch held in decode then flushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_rd | input | 1 | Memory-read control of the instruction in execute (1 = load) |
| ex_rt | input | REG_AW | Destination register number of the instruction in execute |
| id_rs | input | REG_AW | First source register number of the instruction in decode |
| id_rt | input | REG_AW | Second source register number of the instruction in decode |
| id_br_taken | input | 1 | Decode-stage branch resolved as taken |
| pc_en | output | 1 | Program counter write enable |
| ifid_en | output | 1 | Fetch/decode register write enable |
| idex_zero_ctl | output | 1 | Load all-zero control fields into the decode/execute register |
| ifid_flush | output | 1 | Replace fetch/decode contents with an all-zero no-op |

## Verification
The bench targets the dependency on the second source alone. A design that compared only the first source would let the dependent instruction read a stale value. It also targets a load to register 0 that matches a source. A design that skipped the zero test would insert a pointless bubble.

It checks a taken branch that arrives during a stall. A design that flushed at that moment would throw away the held instruction behind the load and skip the branch's own effect. It also drives the bubble cycle that follows a stall. A design that latched the stall would freeze the pipeline for a second cycle, or lose the deferred flush.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Width of a register number in the register file.
  localparam int unsigned REG_AW_DEF = 5;
  // Number of source operands a decoded instruction may read.
  localparam int unsigned NSRC_DEF   = 2;

  // Per-cycle directives to the front of the pipeline.
  typedef struct packed {
    logic pc_en;
    logic ifid_en;
    logic idex_zero_ctl;
    logic ifid_flush;
  } hzd_dir_t;
endpackage

// File: rtl/hzd_load_use_det.sv
module hzd_load_use_det #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned NSRC   = 2
) (
  input  logic                         ex_mem_rd,
  input  logic [REG_AW-1:0]            ex_rt,
  input  logic [NSRC-1:0][REG_AW-1:0]  id_src,
  output logic                         hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [NSRC-1:0] src_match;
  logic            dst_live;

  // Register zero is hard-wired, so a load targeting it carries no data.
  assign dst_live = ex_mem_rd && (ex_rt != ZERO_REG);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_match[s] = (id_src[s] == ex_rt);
  end

  assign hit = dst_live && (|src_match);
endmodule

// File: rtl/hzd_dir_gen.sv
module hzd_dir_gen
  import hzd_pkg::*;
(
  input  logic     stall_req,
  input  logic     br_taken,
  output hzd_dir_t dir
);
  always_comb begin
    dir = '{pc_en: 1'b1, ifid_en: 1'b1, idex_zero_ctl: 1'b0, ifid_flush: 1'b0};
    if (stall_req) begin
      // Hold fetch and decode, push a bubble; the branch waits in decode.
      dir.pc_en         = 1'b0;
      dir.ifid_en       = 1'b0;
      dir.idex_zero_ctl = 1'b1;
    end else if (br_taken) begin
      // Squash the fall-through instruction fetched behind the branch.
      dir.ifid_flush    = 1'b1;
    end
  end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW = REG_AW_DEF
) (
  input  logic              ex_mem_rd,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_br_taken,
  output logic              pc_en,
  output logic              ifid_en,
  output logic              idex_zero_ctl,
  output logic              ifid_flush
);
  localparam int unsigned NSRC = NSRC_DEF;

  logic [NSRC-1:0][REG_AW-1:0] srcs;
  logic                        lu_hit;
  hzd_dir_t                    dir;

  assign srcs[0] = id_rs;
  assign srcs[1] = id_rt;

  hzd_load_use_det #(.REG_AW(REG_AW), .NSRC(NSRC)) u_det (
    .ex_mem_rd (ex_mem_rd),
    .ex_rt     (ex_rt),
    .id_src    (srcs),
    .hit       (lu_hit)
  );

  hzd_dir_gen u_dir (
    .stall_req (lu_hit),
    .br_taken  (id_br_taken),
    .dir       (dir)
  );

  assign pc_en         = dir.pc_en;
  assign ifid_en       = dir.ifid_en;
  assign idex_zero_ctl = dir.idex_zero_ctl;
  assign ifid_flush    = dir.ifid_flush;
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic              ex_mem_rd,
  input logic [REG_AW-1:0] ex_rt,
  input logic [REG_AW-1:0] id_rs,
  input logic [REG_AW-1:0] id_rt,
  input logic              id_br_taken,
  input logic              pc_en,
  input logic              ifid_en,
  input logic              idex_zero_ctl,
  input logic              ifid_flush
);
  logic known;
  assign known = !$isunknown({ex_mem_rd, ex_rt, id_rs, id_rt, id_br_taken,
                              pc_en, ifid_en, idex_zero_ctl, ifid_flush});

  always_comb begin
    if (known) begin
      // R3
      no_stall_noload_chk: assert (ex_mem_rd || !idex_zero_ctl);
      // R4
      no_stall_r0_chk: assert ((ex_rt != '0) || !idex_zero_ctl);
      // R5
      freeze_in_stall_chk: assert (!idex_zero_ctl || (!pc_en && !ifid_en));
      // R8
      no_flush_in_stall_chk: assert (!(ifid_flush && idex_zero_ctl));
      // R7
      flush_on_branch_chk: assert (!(id_br_taken && pc_en) || ifid_flush);
      // R1
      stall_rs_chk: assert (!(ex_mem_rd && ex_rt != '0 && ex_rt == id_rs) || !pc_en);
    end
  end
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.REG_AW(REG_AW)) u_hzd_chk (
  .ex_mem_rd     (ex_mem_rd),
  .ex_rt         (ex_rt),
  .id_rs         (id_rs),
  .id_rt         (id_rt),
  .id_br_taken   (id_br_taken),
  .pc_en         (pc_en),
  .ifid_en       (ifid_en),
  .idex_zero_ctl (idex_zero_ctl),
  .ifid_flush    (ifid_flush)
);

// File: tb/test_hzd_ctrl.sv
module test_hzd_ctrl;
  localparam int AW = 5;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          ex_mem_rd = 1'b0;
  logic [AW-1:0] ex_rt = '0, id_rs = '0, id_rt = '0;
  logic          id_br_taken = 1'b0;
  logic          pc_en, ifid_en, idex_zero_ctl, ifid_flush;
  string         scen = "R9 reset";

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  hzd_ctrl #(.REG_AW(AW)) i_hzd_ctrl (
    .ex_mem_rd(ex_mem_rd), .ex_rt(ex_rt), .id_rs(id_rs), .id_rt(id_rt),
    .id_br_taken(id_br_taken), .pc_en(pc_en), .ifid_en(ifid_en),
    .idex_zero_ctl(idex_zero_ctl), .ifid_flush(ifid_flush)
  );

  // Behavioural reference: walk the list of decode sources.
  function automatic bit ref_stall(bit ld, int dst, int s0, int s1);
    int q[$];
    q.push_back(s0);
    q.push_back(s1);
    if (!ld || dst == 0) return 0;
    foreach (q[i]) if (q[i] == dst) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s: got %b expected %b (cycle %0d)",
               tag, scen, what, got, exp, cyc);
    end
  endtask

  // Compare every clock; inputs change only on the falling edge.
  always @(posedge clk) begin
    bit s, f;
    cyc++;
    s = ref_stall(ex_mem_rd, int'(ex_rt), int'(id_rs), int'(id_rt));
    f = id_br_taken && !s;
    chk("R5", "pc_en",         pc_en,         !s);
    chk("R5", "ifid_en",       ifid_en,       !s);
    chk("R6", "idex_zero_ctl", idex_zero_ctl, s);
    chk("R7", "ifid_flush",    ifid_flush,    f);
  end

  task automatic drive(string tg, bit ld, int dst, int s0, int s1, bit br);
    @(negedge clk);
    scen = tg;
    ex_mem_rd = ld;
    ex_rt = AW'(dst);
    id_rs = AW'(s0);
    id_rt = AW'(s1);
    id_br_taken = br;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    drive("R1 rs match", 1, 7, 7, 3, 0);
    drive("R2 rt match only", 1, 9, 2, 9, 0);
    drive("R2 both match", 1, 4, 4, 4, 0);
    drive("R3 no load, match", 0, 6, 6, 6, 0);
    drive("R4 load r0 matching", 1, 0, 0, 0, 0);
    drive("R4 load r0 branch", 1, 0, 0, 5, 1);
    drive("R9 load no match", 1, 12, 13, 14, 0);
    drive("R7 taken branch", 0, 3, 3, 3, 1);
    drive("R7 taken, load no match", 1, 8, 1, 2, 1);
    drive("R8 stall with branch", 1, 31, 31, 0, 1);
    // Next cycle: bubble now in execute, branch still in decode.
    drive("R10 bubble releases, flush", 0, 0, 31, 0, 1);
    drive("R10 load-use then bubble", 1, 5, 0, 5, 0);
    drive("R10 bubble cycle", 0, 0, 0, 5, 0);
    drive("R9 idle", 0, 0, 0, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      drive("R9 random mix", 1'($urandom), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            1'($urandom));
    end
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d cycles expected fewer", MAX_CYC);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule